// File: doc/BRIEF.md
# Page-Bounded Write Splitter

This block accepts one byte-write request, given as a start address and a byte count, that targets a serial flash organised in 256-byte program pages. It cuts the request into program segments that never straddle a page boundary. The segments are a short leading piece that runs up to the first boundary, then as many complete pages as fit, then a trailing remainder. Each segment carries its flash address, its byte length and its offset into the source buffer. Segments go one at a time to a downstream page-program engine, and the next one is not issued until that engine reports completion.

The engine reports completion with a one-cycle `segDone` and reports failure with `segErr` in the same cycle. On a failure the splitter drops every segment it has not yet issued and ends the request with an error indication. A zero-length request finishes at once and issues nothing. While the full-page part of a large write runs, a one-cycle progress pulse marks each completed group of `PROGRESS_PAGES` whole pages. With the default parameters the group is 1024 pages.

Top module: `page_write_splitter`

## Requirements
- R1: After reset the block is idle. `reqReady` is 1, and `segStart`, `doneValid`, `doneErr` and `progressPulse` are all 0.
- R2: The length of the first segment is the smaller of two values: the request count, and 256 minus the low eight address bits of the start address.
- R3: No segment crosses a page boundary. For every segment, `segAddr[7:0]` plus `segLen` is at most 256, and `segLen` is never 0.
- R4: Every segment after the first starts on a page boundary (`segAddr[7:0]` is 0). A segment is a full 256 bytes whenever at least 256 bytes remain.
- R5: When fewer than 256 bytes remain after the pages, the remainder (1 to 255 bytes) is issued as the last segment. The segment lengths of a request add up to its count.
- R6: Segments are contiguous. Each `segOff` equals the sum of the lengths issued before it in the request, and `segAddr` equals the start address plus `segOff`, taken modulo 2^ADDR_W.
- R7: `segStart` is a one-cycle pulse. No new segment is issued until `segDone` has been received for the previous one.
- R8: A request with a count of 0 issues no segment. It raises `doneValid` with `doneErr` 0 in the first cycle after it is accepted.
- R9: If `segErr` is 1 when `segDone` arrives, no further segment is issued and the request ends with `doneValid` and `doneErr` both 1. Otherwise `doneErr` is 0 at completion.
- R10: `progressPulse` is a one-cycle pulse. It is raised once for every `PROGRESS_PAGES` (1024) full 256-byte segments completed without error within one request. Shorter segments are not counted.
- R11: A request is taken only in a cycle where `reqReady` is 1. A `reqValid` raised while a request is in progress has no effect on the segments issued.
- R12: A `segDone` that arrives while no segment is outstanding is ignored. It causes no completion and no change of state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Write request present |
| reqReady | output | 1 | Splitter idle; request accepted when `reqValid` is also 1 |
| reqAddr | input | ADDR_W | Flash start address of the write |
| reqCount | input | CNT_W | Byte count of the write |
| segStart | output | 1 | One-cycle pulse issuing a segment |
| segAddr | output | ADDR_W | Flash address of the current segment |
| segLen | output | PAGE_BITS+1 | Byte length of the current segment (1 to 256) |
| segOff | output | CNT_W | Source-buffer offset of the current segment |
| segDone | input | 1 | Engine finished the outstanding segment |
| segErr | input | 1 | Engine failure, qualified by `segDone` |
| doneValid | output | 1 | One-cycle pulse when the request ends |
| doneErr | output | 1 | Request ended on an engine failure |
| progressPulse | output | 1 | One-cycle pulse per group of completed full pages |

## Verification
The hardest condition to reach from the ports is the progress pulse. It needs more than a thousand consecutive full-page segments inside one request, and the count must be right when a misaligned head and a short tail surround those pages. Directed requests drive it there. One carries 1023 pages to show that no pulse fires at one page below the threshold, one carries 1024 pages with a head and a tail, and one carries 2048 aligned pages. The engine model answers each segment after a random short delay. Failure injection at a chosen segment index and a stray completion in idle exercise the abort and ignore paths, and seeded random addresses and counts cover the remaining head and tail shapes.

// File: rtl/psplit_pkg.sv
package psplit_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadReq;   // capture a new request
    logic advance;   // current segment completed without error
    logic setErr;    // current segment failed
  } ctlStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ISSUE  = 2'd1,
    ST_WAIT   = 2'd2,
    ST_FINISH = 2'd3
  } splitState_t;

endpackage

// File: rtl/psplit_datapath.sv
module psplit_datapath
  import psplit_pkg::*;
#(
  parameter int ADDR_W         = 24,
  parameter int CNT_W          = 24,
  parameter int PAGE_BITS      = 8,
  parameter int PROGRESS_PAGES = 1024
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobe_t           strobe,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [CNT_W-1:0]     reqCount,
  output logic                 countZero,
  output logic                 lastSeg,
  output logic [ADDR_W-1:0]    curAddr,
  output logic [CNT_W-1:0]     curOff,
  output logic [PAGE_BITS:0]   nextLen,
  output logic                 errFlag,
  output logic                 progressPulse
);

  localparam int PAGE_BYTES = 1 << PAGE_BITS;
  localparam int LEN_W      = PAGE_BITS + 1;
  localparam int PROG_W     = (PROGRESS_PAGES > 1) ? $clog2(PROGRESS_PAGES) : 1;

  logic [CNT_W-1:0]  remain;
  logic [LEN_W-1:0]  toBoundary;
  logic              fullPage;
  logic [PROG_W-1:0] pageCnt;

  // Distance from the current address to the next page boundary (1..PAGE_BYTES)
  assign toBoundary = LEN_W'(PAGE_BYTES) - {1'b0, curAddr[PAGE_BITS-1:0]};
  assign lastSeg    = (remain <= CNT_W'(toBoundary));
  assign nextLen    = lastSeg ? remain[LEN_W-1:0] : toBoundary;
  assign fullPage   = (nextLen == LEN_W'(PAGE_BYTES));
  assign countZero  = (reqCount == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr       <= '0;
      curOff        <= '0;
      remain        <= '0;
      pageCnt       <= '0;
      errFlag       <= 1'b0;
      progressPulse <= 1'b0;
    end else begin
      progressPulse <= 1'b0;
      if (strobe.loadReq) begin
        curAddr <= reqAddr;
        curOff  <= '0;
        remain  <= reqCount;
        pageCnt <= '0;
        errFlag <= 1'b0;
      end else if (strobe.advance) begin
        curAddr <= curAddr + ADDR_W'(nextLen);
        curOff  <= curOff + CNT_W'(nextLen);
        remain  <= remain - CNT_W'(nextLen);
        if (fullPage) begin
          if (pageCnt == PROG_W'(PROGRESS_PAGES - 1)) begin
            pageCnt       <= '0;
            progressPulse <= 1'b1;
          end else begin
            pageCnt <= pageCnt + 1'b1;
          end
        end
      end else if (strobe.setErr) begin
        errFlag <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/psplit_control.sv
module psplit_control
  import psplit_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       countZero,
  input  logic       lastSeg,
  input  logic       segDone,
  input  logic       segErr,
  output ctlStrobe_t strobe,
  output logic       reqReady,
  output logic       segStart,
  output logic       doneValid
);

  splitState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.loadReq = 1'b1;
          stateNext      = countZero ? ST_FINISH : ST_ISSUE;
        end
      end
      ST_ISSUE: stateNext = ST_WAIT;
      ST_WAIT: begin
        if (segDone) begin
          if (segErr) begin
            strobe.setErr = 1'b1;
            stateNext     = ST_FINISH;
          end else begin
            strobe.advance = 1'b1;
            stateNext      = lastSeg ? ST_FINISH : ST_ISSUE;
          end
        end
      end
      ST_FINISH: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign reqReady  = (state == ST_IDLE);
  assign segStart  = (state == ST_ISSUE);
  assign doneValid = (state == ST_FINISH);

endmodule

// File: rtl/page_write_splitter.sv
module page_write_splitter
  import psplit_pkg::*;
#(
  parameter int ADDR_W         = 24,
  parameter int CNT_W          = 24,
  parameter int PAGE_BITS      = 8,
  parameter int PROGRESS_PAGES = 1024
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [CNT_W-1:0]    reqCount,
  output logic                segStart,
  output logic [ADDR_W-1:0]   segAddr,
  output logic [PAGE_BITS:0]  segLen,
  output logic [CNT_W-1:0]    segOff,
  input  logic                segDone,
  input  logic                segErr,
  output logic                doneValid,
  output logic                doneErr,
  output logic                progressPulse
);

  ctlStrobe_t strobe;
  logic       countZero;
  logic       lastSeg;
  logic       errFlag;

  psplit_control u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .countZero (countZero),
    .lastSeg   (lastSeg),
    .segDone   (segDone),
    .segErr    (segErr),
    .strobe    (strobe),
    .reqReady  (reqReady),
    .segStart  (segStart),
    .doneValid (doneValid)
  );

  psplit_datapath #(
    .ADDR_W         (ADDR_W),
    .CNT_W          (CNT_W),
    .PAGE_BITS      (PAGE_BITS),
    .PROGRESS_PAGES (PROGRESS_PAGES)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .reqAddr       (reqAddr),
    .reqCount      (reqCount),
    .countZero     (countZero),
    .lastSeg       (lastSeg),
    .curAddr       (segAddr),
    .curOff        (segOff),
    .nextLen       (segLen),
    .errFlag       (errFlag),
    .progressPulse (progressPulse)
  );

  assign doneErr = doneValid & errFlag;

endmodule

// File: rtl/psplit_checker.sv
module psplit_checker #(
  parameter int ADDR_W    = 24,
  parameter int CNT_W     = 24,
  parameter int PAGE_BITS = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic               reqReady,
  input logic [ADDR_W-1:0]  reqAddr,
  input logic               segStart,
  input logic [ADDR_W-1:0]  segAddr,
  input logic [PAGE_BITS:0] segLen,
  input logic [CNT_W-1:0]   segOff,
  input logic               segDone,
  input logic               segErr,
  input logic               doneValid,
  input logic               progressPulse
);

  localparam int PAGE_BYTES = 1 << PAGE_BITS;

  logic              outstanding;
  logic              errSeen;
  logic [ADDR_W-1:0] expAddr;
  logic [CNT_W-1:0]  expOff;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outstanding <= 1'b0;
      errSeen     <= 1'b0;
      expAddr     <= '0;
      expOff      <= '0;
    end else begin
      if (reqValid && reqReady) begin
        expAddr <= reqAddr;
        expOff  <= '0;
        errSeen <= 1'b0;
      end
      if (segStart) outstanding <= 1'b1;
      if (segDone && outstanding) begin
        outstanding <= 1'b0;
        if (segErr) begin
          errSeen <= 1'b1;
        end else begin
          expAddr <= segAddr + ADDR_W'(segLen);
          expOff  <= segOff + CNT_W'(segLen);
        end
      end
    end
  end

  assert_seg_in_page_R3: assert property (@(posedge clk) disable iff (!rstN)
    segStart |-> (({2'b00, segAddr[PAGE_BITS-1:0]} + {1'b0, segLen}) <= (PAGE_BITS+2)'(PAGE_BYTES)));

  assert_seg_len_nonzero_R3: assert property (@(posedge clk) disable iff (!rstN)
    segStart |-> (segLen != '0));

  assert_aligned_after_first_R4: assert property (@(posedge clk) disable iff (!rstN)
    (segStart && (expOff != '0)) |-> (segAddr[PAGE_BITS-1:0] == '0));

  assert_contiguous_R6: assert property (@(posedge clk) disable iff (!rstN)
    segStart |-> ((segAddr == expAddr) && (segOff == expOff)));

  assert_single_outstanding_R7: assert property (@(posedge clk) disable iff (!rstN)
    segStart |-> !outstanding);

  assert_start_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    segStart |=> !segStart);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  assert_no_issue_after_err_R9: assert property (@(posedge clk) disable iff (!rstN)
    segStart |-> !errSeen);

  assert_progress_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    progressPulse |=> !progressPulse);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!segStart && !outstanding));

endmodule

bind page_write_splitter psplit_checker #(
  .ADDR_W    (ADDR_W),
  .CNT_W     (CNT_W),
  .PAGE_BITS (PAGE_BITS)
) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .reqValid      (reqValid),
  .reqReady      (reqReady),
  .reqAddr       (reqAddr),
  .segStart      (segStart),
  .segAddr       (segAddr),
  .segLen        (segLen),
  .segOff        (segOff),
  .segDone       (segDone),
  .segErr        (segErr),
  .doneValid     (doneValid),
  .progressPulse (progressPulse)
);

// File: tb/tb_page_write_splitter.sv
module tb_page_write_splitter;

  localparam int ADDR_W = 24;
  localparam int CNT_W  = 24;
  localparam int PB     = 8;
  localparam int PROG   = 1024;
  localparam int LOGMAX = 4096;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [CNT_W-1:0]  reqCount = '0;
  logic              segStart;
  logic [ADDR_W-1:0] segAddr;
  logic [PB:0]       segLen;
  logic [CNT_W-1:0]  segOff;
  logic              segDone = 1'b0;
  logic              segErr = 1'b0;
  logic              doneValid;
  logic              doneErr;
  logic              progressPulse;

  page_write_splitter dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqCount(reqCount), .segStart(segStart),
    .segAddr(segAddr), .segLen(segLen), .segOff(segOff),
    .segDone(segDone), .segErr(segErr), .doneValid(doneValid),
    .doneErr(doneErr), .progressPulse(progressPulse)
  );

  always #5 clk = ~clk;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  int segN = 0;
  int progN = 0;
  int errAt = -1;
  logic [ADDR_W-1:0] logAddr [LOGMAX];
  int                logLen  [LOGMAX];
  int                logOff  [LOGMAX];

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // Watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 190000);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
      end
    end
  end

  // Page-program engine model: logs each segment and answers after 1..3 cycles
  initial begin
    @(negedge clk);
    forever begin
      if (segStart) begin
        int myIdx;
        int d;
        myIdx = segN;
        if (segN < LOGMAX) begin
          logAddr[segN] = segAddr;
          logLen[segN]  = int'(segLen);
          logOff[segN]  = int'(segOff);
        end
        segN++;
        d = int'($urandom_range(1, 3));
        repeat (d) @(negedge clk);
        // R7: no further segment while this one is outstanding
        check(!segStart, "R7 segStart while outstanding", segStart, 0);
        segDone = 1'b1;
        segErr  = (myIdx == errAt);
        @(negedge clk);
        segDone = 1'b0;
        segErr  = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
  end

  // Progress pulse counter
  initial begin
    forever begin
      @(negedge clk);
      if (progressPulse) progN++;
    end
  end

  task automatic runReq(input logic [ADDR_W-1:0] a, input int n, input int errIdx,
                        input bit pokeBusy, input string tag);
    int lat;
    logic gotErr;
    logic [ADDR_W-1:0] ea;
    int rem, k, fulls, len;
    bit stop;
    errAt = errIdx;
    segN  = 0;
    progN = 0;
    @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = a;
    reqCount = CNT_W'(n);
    @(negedge clk);
    reqValid = 1'b0;
    reqAddr  = ADDR_W'($urandom);
    reqCount = CNT_W'($urandom_range(1, 600));
    lat = 1;
    while (!doneValid && lat < 100000) begin
      reqValid = 1'b0;
      if (pokeBusy && lat == 3) reqValid = 1'b1; // R11: must be ignored while busy
      @(negedge clk);
      lat++;
    end
    reqValid = 1'b0;
    gotErr = doneErr;
    check(doneValid, {tag, " R9 completion seen"}, doneValid, 1);
    if (n == 0) check(lat == 1, {tag, " R8 zero-count latency"}, lat, 1);

    // Expected segment sequence
    ea = a; rem = n; k = 0; fulls = 0; stop = 0;
    while (rem > 0 && !stop) begin
      len = PROG > 0 ? (256 - int'(ea[7:0])) : 0;
      if (len > rem) len = rem;
      if (k < segN && k < LOGMAX) begin
        bit ok;
        ok = (logAddr[k] == ea) && (logLen[k] == len) && (logOff[k] == n - rem);
        if (!ok) $display("  seg %0d got addr=%h len=%0d off=%0d exp addr=%h len=%0d off=%0d",
                          k, logAddr[k], logLen[k], logOff[k], ea, len, n - rem);
        check(ok, {tag, " R2 R3 R4 R5 R6 segment fields"}, logLen[k], len);
      end
      if (k == errIdx) stop = 1;
      else if (len == 256) fulls++;
      ea  = ea + ADDR_W'(len);
      rem = rem - len;
      k++;
    end
    check(segN == k, {tag, " R5 R9 segment count"}, segN, k);
    check(gotErr == (errIdx >= 0 && errIdx < k), {tag, " R9 doneErr"}, gotErr,
          (errIdx >= 0 && errIdx < k));
    check(progN == fulls / PROG, {tag, " R10 progress pulses"}, progN, fulls / PROG);
    @(negedge clk);
    check(reqReady && !doneValid, {tag, " R1 back to idle"}, reqReady, 1);
  endtask

  initial begin
    void'($urandom(32'd20250117));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(reqReady == 1'b1, "R1 reqReady after reset", reqReady, 1);
    check(!segStart && !doneValid && !doneErr && !progressPulse, "R1 outputs quiet after reset",
          {segStart, doneValid, doneErr, progressPulse}, 0);

    // R12 stray completion in idle
    segDone = 1'b1;
    @(negedge clk);
    segDone = 1'b0;
    check(!doneValid && reqReady && !segStart, "R12 stray segDone ignored",
          {doneValid, reqReady, segStart}, 3'b010);
    @(negedge clk);
    check(!doneValid && reqReady, "R12 still idle", {doneValid, reqReady}, 2'b01);

    runReq(24'h000000, 0,   -1, 0, "zero");          // R8
    runReq(24'h000100, 256, -1, 0, "onepage");       // R4
    runReq(24'h000010, 5,   -1, 0, "short");         // R2
    runReq(24'h0000F0, 16,  -1, 0, "toboundary");    // R2
    runReq(24'h0001F0, 100, -1, 0, "headtail");      // R5
    runReq(24'h030080, 128 + 512 + 7, -1, 0, "headpagestail"); // R4 R5 R6
    runReq(24'hFFFF80, 300, -1, 0, "addrwrap");      // R6
    runReq(24'h001040, 1200, 2, 1, "errmid");        // R9 R11
    runReq(24'h002000, 700, 0, 0, "errfirst");       // R9
    runReq(24'h004000, 600, -1, 1, "busypoke");      // R11
    runReq(24'h100000, 1023 * 256, -1, 0, "pages1023");          // R10
    runReq(24'h000010, 240 + 1024 * 256 + 5, -1, 0, "pages1024"); // R10
    runReq(24'h200000, 2048 * 256, -1, 0, "pages2048");          // R10

    for (int i = 0; i < 25; i++) begin
      logic [ADDR_W-1:0] a;
      int n, e;
      a = ADDR_W'($urandom);
      n = int'($urandom_range(0, 2000));
      e = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 6)) : -1;
      runReq(a, n, e, ($urandom_range(0, 1) == 1), "random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule